// File: doc/BRIEF.md
# Receive Frame Buffer Formatter

This block takes one incoming Ethernet frame at a time as a byte stream and lays it out in a packet page of the controller's buffer memory. The frame length arrives as a sideband that is valid with the first byte. That lets the block compute the status word and the stored byte count before any data arrive. It then claims a page through an allocation handshake and writes the page in a fixed order: status word, byte count, the even part of the data, an optional CRC-32, the trailing byte and a control byte. At the end it pushes the page number into the host's receive queue and raises the receive interrupt.

A frame is not stored, and its bytes are still consumed, in four cases: reception is disabled, soft reset is held, the stored image would not fit in a page, or the allocator has no free page. Frames shorter than the Ethernet minimum are zero-padded before storage. The CRC is computed inside the block over the padded frame.

Top module: `rx_frame_packer`

## Requirements
- R1: The receive-enable and soft-reset settings are sampled on the cycle the first byte of a frame is presented. If enable is 0 or soft reset is 1, the frame is consumed up to its last byte, with no allocation request, no buffer write and no queue push.
- R2: Page bytes 0 and 1 hold the status word (low byte first) and bytes 2 and 3 hold the stored byte count (low byte first). Data start at byte 4.
- R3: Let E be the padded length. The stored count is E rounded down to even, plus 6, plus 4 when the CRC is kept. A frame whose count exceeds the page size (2048 by default) is consumed without an allocation request or any write. A count of exactly 2048 is stored.
- R4: A frame shorter than 64 bytes is stored as 64 bytes, with zeros after its data. The padding is included in the CRC.
- R5: Unless CRC stripping is set, four CRC bytes follow the even data part, low byte first. The CRC is the reflected CRC-32 (polynomial 0xEDB88320), preset to all ones and complemented at the end, over the E stored frame bytes.
- R6: When E is odd, the final frame byte follows the CRC, then the control byte 0x60, and status bit 12 (0x1000) is set. When E is even, a zero byte and then the control byte 0x40 follow.
- R7: Status bit 11 (0x0800) is set when the frame length exceeds 1518 bytes. All other status bits are 0.
- R8: The allocation request is held until it is acknowledged, and no write or byte acceptance happens while it is pending. An acknowledge with failure drops the frame: its bytes are consumed with no write and no push.
- R9: One cycle after the control byte is written, the queue push (carrying the granted page), the receive interrupt and the done pulse are all high together for exactly one cycle. None of them, and no write or request, is active after reset.
- R10: A stored frame makes exactly as many writes as its stored count. They go to consecutive addresses from 0 within the granted page.
- R11: Idle cycles on the input stream do not change the stored image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_en | input | 1 | Reception enabled |
| cfg_soft_rst | input | 1 | Soft reset active, blocks reception |
| cfg_strip_crc | input | 1 | Do not store the CRC |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Final byte of the frame |
| s_len | input | LEN_W | Frame length in bytes, constant over the frame |
| alloc_req | output | 1 | Page request |
| alloc_ack | input | 1 | Allocator answer |
| alloc_ok | input | 1 | A page was granted (with alloc_ack) |
| alloc_page | input | PG_W | Granted page number |
| wr_en | output | 1 | Buffer write strobe |
| wr_page | output | PG_W | Page written |
| wr_addr | output | log2(PAGE_BYTES) | Byte offset in the page |
| wr_data | output | 8 | Byte written |
| q_push | output | 1 | Append page to receive queue |
| q_page | output | PG_W | Page appended |
| rx_irq | output | 1 | Receive interrupt raise pulse |
| done | output | 1 | Frame stored |

## Verification
The bench builds the block with its defaults: a 12-bit length, 2048-byte pages and a 2-bit page number. With a 12-bit length, frames longer than a page can be presented, so both sides of the page limit can be tested. A frame of 2039 bytes with CRC lands exactly on 2048 stored bytes, while 2040 bytes with CRC is dropped and 2040 bytes without CRC is stored. The four page numbers let every stored frame use a different grant, so a wrong page on a write or a push cannot go unnoticed.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int unsigned MIN_FRAME  = 64;
    localparam int unsigned LONG_FRAME = 1518;
    localparam int unsigned HDR_BYTES  = 4;
    localparam int unsigned TAIL_BYTES = 2;
    localparam int unsigned FCS_BYTES  = 4;

    localparam logic [15:0] ST_ODD  = 16'h1000;
    localparam logic [15:0] ST_LONG = 16'h0800;
    localparam logic [7:0]  CTL_EVEN = 8'h40;
    localparam logic [7:0]  CTL_ODD  = 8'h60;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SINK,
        S_ALLOC,
        S_HEAD,
        S_DATA,
        S_PAD,
        S_FCS,
        S_TAIL,
        S_CTRL,
        S_FIN
    } fsm_e;

    // Per-frame layout decisions, fixed when the first byte is presented
    typedef struct packed {
        logic [15:0] status;
        logic [15:0] count;
        logic        keep_fcs;
        logic        odd_tail;
        logic        need_pad;
    } plan_t;

    // One byte of reflected CRC-32, least significant bit first
    function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_frame_plan.sv
module rxf_frame_plan
    import rxf_pkg::*;
#(
    parameter int unsigned LEN_W      = 12,
    parameter int unsigned PAGE_BYTES = 2048
) (
    input  logic [LEN_W-1:0] len,
    input  logic             rx_en,
    input  logic             soft_rst,
    input  logic             strip,
    output plan_t            plan,
    output logic             drop
);
    localparam logic [15:0] MIN16  = 16'(MIN_FRAME);
    localparam logic [15:0] LONG16 = 16'(LONG_FRAME);
    localparam logic [15:0] PAGE16 = 16'(PAGE_BYTES);
    localparam logic [15:0] OVH16  = 16'(HDR_BYTES + TAIL_BYTES);
    localparam logic [15:0] FCS16  = 16'(FCS_BYTES);

    logic [15:0] len16;
    logic [15:0] eff;
    logic [15:0] cnt;

    always_comb begin
        len16 = 16'(len);
        eff   = (len16 < MIN16) ? MIN16 : len16;
        cnt   = {eff[15:1], 1'b0} + OVH16 + (strip ? 16'd0 : FCS16);

        plan.count    = cnt;
        plan.keep_fcs = !strip;
        plan.odd_tail = eff[0];
        plan.need_pad = (len16 < MIN16);
        plan.status   = ((len16 > LONG16) ? ST_LONG : 16'd0)
                      | (eff[0] ? ST_ODD : 16'd0);
        drop          = !rx_en || soft_rst || (cnt > PAGE16);
    end

endmodule

// File: rtl/rxf_crc32.sv
module rxf_crc32
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);
    logic [31:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            acc_q <= '1;
        end else if (upd) begin
            acc_q <= crc_step(acc_q, din);
        end
    end

    assign fcs = ~acc_q;

endmodule

// File: rtl/rxf_emit.sv
module rxf_emit
    import rxf_pkg::*;
(
    input  fsm_e        st,
    input  logic [1:0]  sub,
    input  logic [15:0] status,
    input  logic [15:0] count,
    input  logic        odd,
    input  logic [31:0] fcs,
    input  logic [7:0]  din,
    input  logic [7:0]  trail,
    output logic [7:0]  dout
);
    always_comb begin
        dout = 8'd0;
        unique case (st)
            S_HEAD: begin
                unique case (sub)
                    2'd0:    dout = status[7:0];
                    2'd1:    dout = status[15:8];
                    2'd2:    dout = count[7:0];
                    default: dout = count[15:8];
                endcase
            end
            S_DATA:  dout = din;
            S_FCS:   dout = fcs[8*sub +: 8];
            S_TAIL:  dout = odd ? trail : 8'd0;
            S_CTRL:  dout = odd ? CTL_ODD : CTL_EVEN;
            default: dout = 8'd0;
        endcase
    end

endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer
    import rxf_pkg::*;
#(
    parameter int unsigned LEN_W      = 12,
    parameter int unsigned PAGE_BYTES = 2048,
    parameter int unsigned PG_W       = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_rx_en,
    input  logic                          cfg_soft_rst,
    input  logic                          cfg_strip_crc,
    input  logic                          s_valid,
    output logic                          s_ready,
    input  logic [7:0]                    s_data,
    input  logic                          s_last,
    input  logic [LEN_W-1:0]              s_len,
    output logic                          alloc_req,
    input  logic                          alloc_ack,
    input  logic                          alloc_ok,
    input  logic [PG_W-1:0]               alloc_page,
    output logic                          wr_en,
    output logic [PG_W-1:0]               wr_page,
    output logic [$clog2(PAGE_BYTES)-1:0] wr_addr,
    output logic [7:0]                    wr_data,
    output logic                          q_push,
    output logic [PG_W-1:0]               q_page,
    output logic                          rx_irq,
    output logic                          done
);
    localparam int unsigned AW = $clog2(PAGE_BYTES);
    localparam logic [15:0] PAD_END = 16'(MIN_FRAME - 1);

    fsm_e            st_q;
    plan_t           plan_q;
    plan_t           plan_now;
    logic            drop_now;
    logic [PG_W-1:0] page_q;
    logic [AW-1:0]   addr_q;
    logic [15:0]     pos_q;
    logic [1:0]      sub_q;
    logic [7:0]      trail_q;
    logic [31:0]     fcs;
    logic            hold_tail;
    logic            crc_upd;
    fsm_e            body_next;

    rxf_frame_plan #(
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_plan (
        .len      (s_len),
        .rx_en    (cfg_rx_en),
        .soft_rst (cfg_soft_rst),
        .strip    (cfg_strip_crc),
        .plan     (plan_now),
        .drop     (drop_now)
    );

    assign crc_upd = ((st_q == S_DATA) && s_valid) || (st_q == S_PAD);

    rxf_crc32 u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (st_q == S_IDLE),
        .upd  (crc_upd),
        .din  ((st_q == S_DATA) ? s_data : 8'd0),
        .fcs  (fcs)
    );

    rxf_emit u_emit (
        .st     (st_q),
        .sub    (sub_q),
        .status (plan_q.status),
        .count  (plan_q.count),
        .odd    (plan_q.odd_tail),
        .fcs    (fcs),
        .din    (s_data),
        .trail  (trail_q),
        .dout   (wr_data)
    );

    // The final byte of an odd padded length is kept back until after the CRC
    assign hold_tail = s_last && plan_q.odd_tail;
    assign body_next = plan_q.keep_fcs ? S_FCS : S_TAIL;

    always_comb begin
        s_ready   = (st_q == S_DATA) || (st_q == S_SINK);
        alloc_req = (st_q == S_ALLOC);
        unique case (st_q)
            S_HEAD, S_PAD, S_FCS, S_TAIL, S_CTRL: wr_en = 1'b1;
            S_DATA:  wr_en = s_valid && !hold_tail;
            default: wr_en = 1'b0;
        endcase
    end

    assign wr_page = page_q;
    assign wr_addr = addr_q;
    assign q_page  = page_q;
    assign q_push  = (st_q == S_FIN);
    assign rx_irq  = (st_q == S_FIN);
    assign done    = (st_q == S_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            plan_q  <= '0;
            page_q  <= '0;
            addr_q  <= '0;
            pos_q   <= '0;
            sub_q   <= '0;
            trail_q <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (s_valid) begin
                        plan_q <= plan_now;
                        st_q   <= drop_now ? S_SINK : S_ALLOC;
                    end
                end
                S_SINK: begin
                    if (s_valid && s_last) begin
                        st_q <= S_IDLE;
                    end
                end
                S_ALLOC: begin
                    if (alloc_ack) begin
                        if (alloc_ok) begin
                            page_q <= alloc_page;
                            addr_q <= '0;
                            sub_q  <= '0;
                            st_q   <= S_HEAD;
                        end else begin
                            st_q <= S_SINK;
                        end
                    end
                end
                S_HEAD: begin
                    addr_q <= addr_q + 1'b1;
                    sub_q  <= sub_q + 1'b1;
                    if (sub_q == 2'd3) begin
                        pos_q <= '0;
                        st_q  <= S_DATA;
                    end
                end
                S_DATA: begin
                    if (s_valid) begin
                        pos_q <= pos_q + 1'b1;
                        if (hold_tail) begin
                            trail_q <= s_data;
                        end else begin
                            addr_q <= addr_q + 1'b1;
                        end
                        if (s_last) begin
                            sub_q <= '0;
                            st_q  <= plan_q.need_pad ? S_PAD : body_next;
                        end
                    end
                end
                S_PAD: begin
                    addr_q <= addr_q + 1'b1;
                    pos_q  <= pos_q + 1'b1;
                    if (pos_q == PAD_END) begin
                        st_q <= body_next;
                    end
                end
                S_FCS: begin
                    addr_q <= addr_q + 1'b1;
                    sub_q  <= sub_q + 1'b1;
                    if (sub_q == 2'd3) begin
                        st_q <= S_TAIL;
                    end
                end
                S_TAIL: begin
                    addr_q <= addr_q + 1'b1;
                    st_q   <= S_CTRL;
                end
                S_CTRL: begin
                    addr_q <= addr_q + 1'b1;
                    st_q   <= S_FIN;
                end
                S_FIN: begin
                    st_q <= S_IDLE;
                end
                default: begin
                    st_q <= S_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
    parameter int unsigned PG_W = 2,
    parameter int unsigned AW   = 11
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_rx_en,
    input logic            cfg_soft_rst,
    input logic            s_ready,
    input logic            alloc_req,
    input logic            alloc_ack,
    input logic            wr_en,
    input logic [PG_W-1:0] wr_page,
    input logic [AW-1:0]   wr_addr,
    input logic            q_push,
    input logic            rx_irq,
    input logic            done
);
    // R8
    alloc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_req && !alloc_ack |=> alloc_req);

    // R8
    alloc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_req |-> !wr_en && !s_ready);

    // R1
    admit_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alloc_req) |-> $past(cfg_rx_en) && !$past(cfg_soft_rst));

    // R10
    wr_seq_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && $past(wr_en) |-> (wr_addr == $past(wr_addr) + 1'b1) && (wr_page == $past(wr_page)));

    // R9
    push_trio_chk: assert property (@(posedge clk) disable iff (rst)
        q_push |-> rx_irq && done && $past(wr_en));

    // R9
    push_single_chk: assert property (@(posedge clk) disable iff (rst)
        q_push |=> !q_push && !rx_irq && !done);

endmodule

bind rx_frame_packer rxf_chk #(
    .PG_W (PG_W),
    .AW   (AW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_rx_en    (cfg_rx_en),
    .cfg_soft_rst (cfg_soft_rst),
    .s_ready      (s_ready),
    .alloc_req    (alloc_req),
    .alloc_ack    (alloc_ack),
    .wr_en        (wr_en),
    .wr_page      (wr_page),
    .wr_addr      (wr_addr),
    .q_push       (q_push),
    .rx_irq       (rx_irq),
    .done         (done)
);

// File: tb/sim_rx_frame_packer.sv
`timescale 1ns/1ps
module sim_rx_frame_packer;
    localparam int LEN_W      = 12;
    localparam int PAGE_BYTES = 2048;
    localparam int PG_W       = 2;
    localparam int AW         = $clog2(PAGE_BYTES);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_rx_en = 1'b1;
    logic             cfg_soft_rst = 1'b0;
    logic             cfg_strip_crc = 1'b0;
    logic             s_valid = 1'b0;
    logic             s_ready;
    logic [7:0]       s_data = 8'd0;
    logic             s_last = 1'b0;
    logic [LEN_W-1:0] s_len = '0;
    logic             alloc_req;
    logic             alloc_ack = 1'b0;
    logic             alloc_ok = 1'b0;
    logic [PG_W-1:0]  alloc_page = '0;
    logic             wr_en;
    logic [PG_W-1:0]  wr_page;
    logic [AW-1:0]    wr_addr;
    logic [7:0]       wr_data;
    logic             q_push;
    logic [PG_W-1:0]  q_page;
    logic             rx_irq;
    logic             done;

    always #2.5 clk = ~clk;

    rx_frame_packer #(
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES),
        .PG_W       (PG_W)
    ) u0 (
        .clk (clk), .rst (rst),
        .cfg_rx_en (cfg_rx_en), .cfg_soft_rst (cfg_soft_rst), .cfg_strip_crc (cfg_strip_crc),
        .s_valid (s_valid), .s_ready (s_ready), .s_data (s_data), .s_last (s_last), .s_len (s_len),
        .alloc_req (alloc_req), .alloc_ack (alloc_ack), .alloc_ok (alloc_ok), .alloc_page (alloc_page),
        .wr_en (wr_en), .wr_page (wr_page), .wr_addr (wr_addr), .wr_data (wr_data),
        .q_push (q_push), .q_page (q_page), .rx_irq (rx_irq), .done (done)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] cap  [0:PAGE_BYTES-1];
    logic [7:0] expv [0:PAGE_BYTES-1];
    int wr_cnt, push_cnt, req_cnt, page_bad, trio_bad;
    logic [PG_W-1:0] last_qpage;
    logic [PG_W-1:0] want_page;
    bit grant_ok;
    bit prev_req = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((i * 13) + (seed * 7) + (i >> 8));
    endfunction

    // Monitor and allocator model, sampled after the inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst) begin
                alloc_ack = 1'b0;
                prev_req = 1'b0;
            end else begin
                if (alloc_req && !prev_req) req_cnt++;
                prev_req = alloc_req;
                if (alloc_req && !alloc_ack) begin
                    alloc_ack  = 1'b1;
                    alloc_ok   = grant_ok;
                    alloc_page = want_page;
                end else begin
                    alloc_ack = 1'b0;
                end
                if (wr_en) begin
                    cap[wr_addr] = wr_data;
                    wr_cnt++;
                    if (wr_page != want_page) page_bad++;
                end
                if (q_push || rx_irq || done) begin
                    if (!(q_push && rx_irq && done)) trio_bad++;
                    if (q_push) begin
                        push_cnt++;
                        last_qpage = q_page;
                    end
                end
            end
        end
    end

    task automatic send_frame(input int len, input int seed, input bit gaps);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (gaps && (i % 3 == 1)) begin
                s_valid = 1'b0;
                @(negedge clk);
            end
            s_valid = 1'b1;
            s_data  = pat(seed, i);
            s_last  = (i == len - 1);
            s_len   = LEN_W'(len);
            while (!s_ready) @(negedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic run_frame(input string tag, input int len, input int seed, input bit strip,
                             input bit en, input bit srst, input bit ok, input int page,
                             input bit gaps, input bit store);
        int eff, even, cnt, p, bad, first;
        logic [31:0] c;
        logic [15:0] stw;
        logic [7:0] b;
        @(negedge clk);
        cfg_rx_en = en;
        cfg_soft_rst = srst;
        cfg_strip_crc = strip;
        grant_ok = ok;
        want_page = PG_W'(page);
        wr_cnt = 0; push_cnt = 0; req_cnt = 0; page_bad = 0; trio_bad = 0;
        for (int i = 0; i < PAGE_BYTES; i++) cap[i] = 8'h00;
        send_frame(len, seed, gaps);
        repeat (80) @(negedge clk);

        if (!store) begin
            chk(wr_cnt == 0, tag, "writes on dropped frame", wr_cnt, 0);
            chk(push_cnt == 0, tag, "pushes on dropped frame", push_cnt, 0);
            chk(req_cnt == (ok ? 0 : 1), tag, "allocation requests", req_cnt, ok ? 0 : 1);
            return;
        end

        // Expected image from the layout rules
        eff  = (len < 64) ? 64 : len;
        even = eff & ~1;
        cnt  = even + 6 + (strip ? 0 : 4);
        stw  = ((len > 1518) ? 16'h0800 : 16'h0000) | ((eff % 2 == 1) ? 16'h1000 : 16'h0000);
        expv[0] = stw[7:0];
        expv[1] = stw[15:8];
        expv[2] = 8'(cnt);
        expv[3] = 8'(cnt >> 8);
        c = 32'hFFFFFFFF;
        for (int i = 0; i < eff; i++) begin
            b = (i < len) ? pat(seed, i) : 8'h00;
            if (i < even) expv[4 + i] = b;
            c = c ^ {24'd0, b};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        p = 4 + even;
        if (!strip) begin
            for (int k = 0; k < 4; k++) expv[p + k] = c[8*k +: 8];
            p = p + 4;
        end
        expv[p]     = (eff % 2 == 1) ? pat(seed, eff - 1) : 8'h00;
        expv[p + 1] = (eff % 2 == 1) ? 8'h60 : 8'h40;

        bad = 0; first = -1;
        for (int i = 0; i < cnt; i++) begin
            if (cap[i] !== expv[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first >= 0) chk(1'b0, tag, $sformatf("image byte %0d", first), int'(cap[first]), int'(expv[first]));
        else chk(1'b1, tag, "image", 0, 0);
        // R10 write count equals stored count, all to the granted page
        chk(wr_cnt == cnt && page_bad == 0, {tag, " R10"}, "write count", wr_cnt, cnt);
        // R9 one push with the granted page, pulses aligned
        chk(push_cnt == 1 && last_qpage == PG_W'(page) && trio_bad == 0, {tag, " R9"},
            "push count/page", push_cnt * 16 + int'(last_qpage), 16 + page);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R9 reset state
        chk(!wr_en && !q_push && !rx_irq && !done && !alloc_req && !s_ready, "R9", "idle after reset",
            int'({wr_en, q_push, rx_irq, done, alloc_req, s_ready}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!wr_en && !q_push && !alloc_req, "R9", "idle after release", int'({wr_en, q_push, alloc_req}), 0);

        run_frame("R2 R5 R6", 100, 1, 0, 1, 0, 1, 1, 0, 1);
        run_frame("R6 R11",   101, 2, 0, 1, 0, 1, 2, 1, 1);
        run_frame("R4",        11, 3, 0, 1, 0, 1, 3, 0, 1);
        run_frame("R4 R5",     64, 4, 1, 1, 0, 1, 0, 0, 1);
        run_frame("R5 R6",     75, 5, 1, 1, 0, 1, 0, 0, 1);
        run_frame("R7",      1600, 6, 0, 1, 0, 1, 1, 0, 1);
        run_frame("R3",      2039, 7, 0, 1, 0, 1, 2, 0, 1);
        run_frame("R3",      2040, 8, 0, 1, 0, 1, 2, 0, 0);
        run_frame("R3",      2040, 9, 1, 1, 0, 1, 3, 0, 1);
        run_frame("R1",        80, 10, 0, 0, 0, 1, 1, 0, 0);
        run_frame("R1",        80, 11, 0, 1, 1, 1, 1, 0, 0);
        run_frame("R8",        90, 12, 0, 1, 0, 0, 2, 0, 0);
        run_frame("R8",        90, 13, 0, 1, 0, 1, 0, 1, 1);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule